// File: doc/BRIEF.md
# IO address translation table walker

This block sits between an I/O bus DMA port and system memory. It turns each I/O virtual address into a physical address with read and write permissions and a page size. When translation is on, the block works out where the matching entry sits in a translation table in memory. It reads that 64-bit entry with a single request on a memory request/response interface, then decodes the entry. When translation is off, addresses pass straight through with full permission on an 8 KB granule.

Software sets the block up through two 64-bit registers on a small register port. One holds control: the enable, the table format and the table size. The other holds the table base address. Either register can be reached as a whole 64-bit word or as two 32-bit halves. Only one translation is handled at a time. The block takes a copy of the configuration and the address when it accepts a request, so register writes made during a walk apply from the next request on.

Top module: `iott_walker`

## Requirements
- R1: After reset both registers read as zero, `xl_req_ready` is 1, and `xl_rsp_valid` and `mem_req_valid` are 0.
- R2: The control register sits at byte offset 0x0 and the base register at 0x8. A 64-bit access (`reg_wide`=1) at either offset reaches the whole register. A 32-bit access at the offset itself reaches bits 63:32, and a 32-bit access at offset+4 reaches bits 31:0. Narrow data travels on bits 31:0 of `reg_wdata`/`reg_rdata`, and the upper read bits are zero.
- R3: Writes to any other offset or width combination (for example 0x10, 0x14, 0x2, or a wide access at 0x4) change no register, and reads there return zero.
- R4: When control bit 0 is 0, an accepted request produces a result in the next cycle with `xl_rsp_paddr` equal to the input address, both permissions set and `xl_rsp_big`=0. No memory request is issued.
- R5: With control bit 0 set and control bit 2 clear (8 KB format), the memory read address is base + 8·(input[22+n:13]), where n is control bits 18:16 (0 to 7).
- R6: With control bits 0 and 2 set (64 KB format) and n from 0 to 5, the memory read address is base + 8·(input[25+n:16]).
- R7: In 64 KB format with n equal to 6 or 7, the result is no access (both permissions 0, address 0, big 0) in the next cycle, and no memory request is issued.
- R8: `mem_rsp_data` carries the byte at the lowest memory address on bits 7:0. The entry is the big-endian value of those eight bytes, so it is the byte-reversed bus word.
- R9: An entry with bit 63 clear gives a no-access result: permissions 0, address 0, big 0.
- R10: A valid entry always grants read. It also grants write exactly when entry bit 1 is set.
- R11: If entry bit 61 is set, `xl_rsp_big`=1 and the address is {entry[40:16], input[15:0]}. Otherwise the address is {entry[40:13], input[12:0]}. Bits above 40 are zero in both cases.
- R12: `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen. `xl_req_ready` stays low from acceptance until the response. `xl_rsp_valid` pulses for exactly one cycle, in the cycle after `mem_rsp_valid`.
- R13: Register writes made while a walk is in flight change neither that walk's memory address nor its result. They apply to the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| xl_req_valid | input | 1 | Translation request valid |
| xl_req_ready | output | 1 | Walker can accept a request |
| xl_req_addr | input | 64 | I/O virtual address |
| xl_rsp_valid | output | 1 | One-cycle result pulse |
| xl_rsp_paddr | output | 64 | Translated physical address |
| xl_rsp_rd_ok | output | 1 | Read allowed |
| xl_rsp_wr_ok | output | 1 | Write allowed |
| xl_rsp_big | output | 1 | 1 = 64 KB page, 0 = 8 KB |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry bus word, lowest-address byte in bits 7:0 |

## Verification
Passthrough and bad-size results are due in the cycle after the accepting edge. A walk's memory request is also visible in that cycle. The translated result is due in the cycle after the edge where `mem_rsp_valid` is sampled. Register reads are combinational and register writes apply at the edge that samples them. The bench drives inputs on falling edges and samples at the falling edge one cycle after each relevant rising edge. While it holds back `mem_req_ready` or the response, it checks at every falling edge that the request is held, that the result has not yet appeared, and that the pulse is gone one cycle after it appears.

// File: rtl/iott_pkg.sv
package iott_pkg;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned HALF_W   = 32;
  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_BIG  = 2;
  localparam int unsigned CTL_SZ   = 16;
  localparam int unsigned SZ_W     = 3;
  localparam int unsigned ENT_V    = 63;
  localparam int unsigned ENT_BIG  = 61;
  localparam int unsigned ENT_W    = 1;
  localparam int unsigned PA_TOP   = 40;
  localparam int unsigned SH_SMALL = 13;
  localparam int unsigned SH_BIG   = 16;
  localparam int unsigned IDX_MIN  = 10;
  localparam int unsigned BIG_MAXN = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT} walk_st_e;

  typedef struct packed {
    logic [WORD_W-1:0] paddr;
    logic              rd_ok;
    logic              wr_ok;
    logic              big;
  } xl_res_t;

  function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int k = 0; k < WORD_W/8; k++) r[8*k +: 8] = w[WORD_W-8-8*k +: 8];
    return r;
  endfunction

  // Byte offset of the entry in the table: selected index bits, times 8.
  function automatic logic [WORD_W-1:0] table_offset(input logic [WORD_W-1:0] iova,
                                                     input logic big,
                                                     input logic [SZ_W-1:0] n);
    int unsigned lo, hi;
    logic [WORD_W-1:0] m;
    lo = big ? SH_BIG : SH_SMALL;
    hi = lo + IDX_MIN - 1 + int'(n);
    m  = '0;
    for (int i = 0; i < WORD_W; i++)
      if (i >= int'(lo) && i <= int'(hi)) m[i] = iova[i];
    return m >> (lo - 3);
  endfunction

  function automatic logic size_legal(input logic big, input logic [SZ_W-1:0] n);
    return !big || (n <= SZ_W'(BIG_MAXN));
  endfunction

  function automatic xl_res_t no_access();
    xl_res_t r;
    r = '0;
    return r;
  endfunction

  function automatic xl_res_t pass_through(input logic [WORD_W-1:0] iova);
    xl_res_t r;
    r.paddr = iova;
    r.rd_ok = 1'b1;
    r.wr_ok = 1'b1;
    r.big   = 1'b0;
    return r;
  endfunction

  function automatic xl_res_t decode_entry(input logic [WORD_W-1:0] ent,
                                           input logic [WORD_W-1:0] iova);
    xl_res_t r;
    r = '0;
    if (ent[ENT_V]) begin
      r.rd_ok = 1'b1;
      r.wr_ok = ent[ENT_W];
      r.big   = ent[ENT_BIG];
      for (int i = 0; i <= PA_TOP; i++) begin
        if (i < (ent[ENT_BIG] ? SH_BIG : SH_SMALL)) r.paddr[i] = iova[i];
        else                                         r.paddr[i] = ent[i];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/iott_regs.sv
module iott_regs
  import iott_pkg::*;
#(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned NREG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic              reg_wide,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] base_q
);
  logic [NREG-1:0][WORD_W-1:0] regs_all;
  logic [NREG-1:0][WORD_W-1:0] rd_part;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [REG_AW-1:0] OFF_HI = REG_AW'(g * 8);
    localparam logic [REG_AW-1:0] OFF_LO = REG_AW'(g * 8 + 4);
    logic hit_full, hit_hi, hit_lo;
    logic [WORD_W-1:0] r_q;

    assign hit_full = (reg_addr == OFF_HI) && reg_wide;
    assign hit_hi   = (reg_addr == OFF_HI) && !reg_wide;
    assign hit_lo   = (reg_addr == OFF_LO) && !reg_wide;

    always_ff @(posedge clk) begin
      if (!rst_n) r_q <= '0;
      else if (reg_en && reg_we) begin
        if (hit_full)    r_q <= reg_wdata;
        else if (hit_hi) r_q[WORD_W-1:HALF_W] <= reg_wdata[HALF_W-1:0];
        else if (hit_lo) r_q[HALF_W-1:0] <= reg_wdata[HALF_W-1:0];
      end
    end

    always_comb begin
      rd_part[g] = '0;
      if (hit_full)    rd_part[g] = r_q;
      else if (hit_hi) rd_part[g] = {{HALF_W{1'b0}}, r_q[WORD_W-1:HALF_W]};
      else if (hit_lo) rd_part[g] = {{HALF_W{1'b0}}, r_q[HALF_W-1:0]};
    end

    assign regs_all[g] = r_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_en && !reg_we)
      for (int g = 0; g < NREG; g++) reg_rdata = reg_rdata | rd_part[g];
  end

  assign ctrl_q = regs_all[0];
  assign base_q = regs_all[1];
endmodule

// File: rtl/iott_index.sv
module iott_index
  import iott_pkg::*;
(
  input  logic [WORD_W-1:0] iova,
  input  logic [WORD_W-1:0] ctrl,
  input  logic [WORD_W-1:0] base,
  output logic              cfg_en,
  output logic              cfg_big_fmt,
  output logic [SZ_W-1:0]   cfg_size,
  output logic              size_ok,
  output logic [WORD_W-1:0] fetch_addr
);
  assign cfg_en      = ctrl[CTL_EN];
  assign cfg_big_fmt = ctrl[CTL_BIG];
  assign cfg_size    = ctrl[CTL_SZ +: SZ_W];
  assign size_ok     = size_legal(cfg_big_fmt, cfg_size);
  assign fetch_addr  = base + table_offset(iova, cfg_big_fmt, cfg_size);
endmodule

// File: rtl/iott_decode.sv
module iott_decode
  import iott_pkg::*;
(
  input  logic [WORD_W-1:0] bus_word,
  input  logic [WORD_W-1:0] iova,
  output logic [WORD_W-1:0] entry,
  output xl_res_t           res
);
  assign entry = byte_rev(bus_word);
  assign res   = decode_entry(entry, iova);
endmodule

// File: rtl/iott_walker.sv
module iott_walker
  import iott_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic              reg_wide,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              xl_req_valid,
  output logic              xl_req_ready,
  input  logic [63:0]       xl_req_addr,
  output logic              xl_rsp_valid,
  output logic [63:0]       xl_rsp_paddr,
  output logic              xl_rsp_rd_ok,
  output logic              xl_rsp_wr_ok,
  output logic              xl_rsp_big,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data
);
  logic [WORD_W-1:0] ctrl_q, base_q, fetch_addr, entry_w;
  logic              cfg_en, cfg_big_fmt, size_ok;
  logic [SZ_W-1:0]   cfg_size;
  logic              acc_fire, wait_rsp;
  walk_st_e          st_q;
  logic [WORD_W-1:0] iova_q, fetch_q;
  xl_res_t           res_q, dec_res;
  logic              rsp_v_q;

  iott_regs #(.REG_AW(REG_AW), .NREG(2)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ctrl_q(ctrl_q), .base_q(base_q)
  );

  iott_index u_index (
    .iova(xl_req_addr), .ctrl(ctrl_q), .base(base_q),
    .cfg_en(cfg_en), .cfg_big_fmt(cfg_big_fmt), .cfg_size(cfg_size),
    .size_ok(size_ok), .fetch_addr(fetch_addr)
  );

  iott_decode u_decode (
    .bus_word(mem_rsp_data), .iova(iova_q), .entry(entry_w), .res(dec_res)
  );

  assign xl_req_ready = (st_q == ST_IDLE);
  assign acc_fire     = xl_req_valid && xl_req_ready;
  assign wait_rsp     = (st_q == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      iova_q  <= '0;
      fetch_q <= '0;
      res_q   <= '0;
      rsp_v_q <= 1'b0;
    end else begin
      rsp_v_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (acc_fire) begin
          iova_q <= xl_req_addr;
          if (!cfg_en) begin
            res_q   <= pass_through(xl_req_addr);
            rsp_v_q <= 1'b1;
          end else if (!size_ok) begin
            res_q   <= no_access();
            rsp_v_q <= 1'b1;
          end else begin
            fetch_q <= fetch_addr;
            st_q    <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          res_q   <= dec_res;
          rsp_v_q <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st_q == ST_FETCH);
  assign mem_req_addr  = fetch_q;
  assign xl_rsp_valid  = rsp_v_q;
  assign xl_rsp_paddr  = res_q.paddr;
  assign xl_rsp_rd_ok  = res_q.rd_ok;
  assign xl_rsp_wr_ok  = res_q.wr_ok;
  assign xl_rsp_big    = res_q.big;
endmodule

// File: rtl/iott_walker_chk.sv
module iott_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_fire,
  input logic        wait_rsp,
  input logic        cfg_en,
  input logic        cfg_big_fmt,
  input logic [2:0]  cfg_size,
  input logic [63:0] xl_req_addr,
  input logic        xl_req_ready,
  input logic        xl_rsp_valid,
  input logic [63:0] xl_rsp_paddr,
  input logic        xl_rsp_rd_ok,
  input logic        xl_rsp_wr_ok,
  input logic        xl_rsp_big,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        mem_rsp_valid
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R12
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || wait_rsp) |-> !xl_req_ready); // R12
  AST_RSP_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    wait_rsp && mem_rsp_valid |=> xl_rsp_valid); // R12
  AST_PASS_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !cfg_en |=> xl_rsp_valid && !mem_req_valid); // R4
  AST_PASS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !cfg_en |=> xl_rsp_paddr == $past(xl_req_addr) && xl_rsp_rd_ok
                            && xl_rsp_wr_ok && !xl_rsp_big); // R4
  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && cfg_en && cfg_big_fmt && cfg_size >= 3'd6
      |=> xl_rsp_valid && !xl_rsp_rd_ok && !mem_req_valid); // R7
  AST_NOACCESS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    xl_rsp_valid && !xl_rsp_rd_ok |-> !xl_rsp_wr_ok && xl_rsp_paddr == 64'd0 && !xl_rsp_big); // R9
  AST_WR_IMPLIES_RD: assert property (@(posedge clk) disable iff (!rst_n)
    xl_rsp_valid && xl_rsp_wr_ok |-> xl_rsp_rd_ok); // R10
endmodule

bind iott_walker iott_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .wait_rsp(wait_rsp),
  .cfg_en(cfg_en), .cfg_big_fmt(cfg_big_fmt), .cfg_size(cfg_size),
  .xl_req_addr(xl_req_addr), .xl_req_ready(xl_req_ready),
  .xl_rsp_valid(xl_rsp_valid), .xl_rsp_paddr(xl_rsp_paddr),
  .xl_rsp_rd_ok(xl_rsp_rd_ok), .xl_rsp_wr_ok(xl_rsp_wr_ok),
  .xl_rsp_big(xl_rsp_big), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/tb_iott_walker.sv
module tb_iott_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0, reg_wide = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        xl_req_valid = 1'b0;
  logic        xl_req_ready;
  logic [63:0] xl_req_addr = '0;
  logic        xl_rsp_valid;
  logic [63:0] xl_rsp_paddr;
  logic        xl_rsp_rd_ok, xl_rsp_wr_ok, xl_rsp_big;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  iott_walker dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .xl_req_valid(xl_req_valid),
    .xl_req_ready(xl_req_ready), .xl_req_addr(xl_req_addr),
    .xl_rsp_valid(xl_rsp_valid), .xl_rsp_paddr(xl_rsp_paddr),
    .xl_rsp_rd_ok(xl_rsp_rd_ok), .xl_rsp_wr_ok(xl_rsp_wr_ok),
    .xl_rsp_big(xl_rsp_big), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input bit wide, input logic [63:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_wide = wide; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input logic [4:0] a, input bit wide, output logic [63:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_wide = wide; reg_addr = a;
    #1 d = reg_rdata;
    reg_en = 0;
  endtask

  function automatic logic [63:0] swap8(input logic [63:0] w);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = w[63-8*k -: 8];
    return r;
  endfunction

  // Expected result fields {paddr, rd, wr, big} from an entry per R9-R11.
  task automatic exp_entry(input logic [63:0] e, input logic [63:0] va,
                           output logic [63:0] pa, output bit rd, output bit wr,
                           output bit bg);
    pa = 0; rd = 0; wr = 0; bg = 0;
    if (e[63]) begin
      rd = 1; wr = e[1]; bg = e[61];
      if (bg) pa = (e & 64'h1ff_ffff_0000) | (va & 64'hffff);
      else    pa = (e & 64'h1ff_ffff_e000) | (va & 64'h1fff);
    end
  endtask

  task automatic check_rsp(input string tag, input logic [63:0] pa, input bit rd,
                           input bit wr, input bit bg);
    chk(xl_rsp_valid == 1'b1, {tag, " rsp_valid"}, 64'(xl_rsp_valid), 64'd1);
    chk(xl_rsp_paddr == pa, {tag, " paddr"}, xl_rsp_paddr, pa);
    chk(xl_rsp_rd_ok == rd && xl_rsp_wr_ok == wr, {tag, " perm"},
        {62'd0, xl_rsp_rd_ok, xl_rsp_wr_ok}, {62'd0, rd, wr});
    chk(xl_rsp_big == bg, {tag, " big"}, 64'(xl_rsp_big), 64'(bg));
  endtask

  // One translation; ctl/bas are the programmed registers used for expectations.
  task automatic xlate(input logic [63:0] va, input logic [63:0] ctl,
                       input logic [63:0] bas, input logic [63:0] ent,
                       input int rdly, input int sdly);
    logic [63:0] pa, ea, ofs;
    bit rd, wr, bg;
    int n;
    n = int'(ctl[18:16]);
    @(negedge clk);
    xl_req_valid = 1; xl_req_addr = va;
    #1 chk(xl_req_ready == 1'b1, "R12 ready idle", 64'(xl_req_ready), 64'd1);
    @(negedge clk);
    xl_req_valid = 0;
    if (!ctl[0]) begin
      chk(mem_req_valid == 1'b0, "R4 no fetch", 64'(mem_req_valid), 64'd0);
      check_rsp("R4 passthrough", va, 1, 1, 0);
    end else if (ctl[2] && n >= 6) begin
      chk(mem_req_valid == 1'b0, "R7 no fetch", 64'(mem_req_valid), 64'd0);
      check_rsp("R7 bad size", 64'd0, 0, 0, 0);
    end else begin
      if (ctl[2]) ofs = ((va >> 16) & ((64'd1 << (10 + n)) - 1)) * 8;
      else        ofs = ((va >> 13) & ((64'd1 << (10 + n)) - 1)) * 8;
      ea = bas + ofs;
      chk(mem_req_valid == 1'b1, "R12 fetch issued", 64'(mem_req_valid), 64'd1);
      chk(mem_req_addr == ea, ctl[2] ? "R6 index 64k" : "R5 index 8k", mem_req_addr, ea);
      chk(xl_req_ready == 1'b0, "R12 busy", 64'(xl_req_ready), 64'd0);
      for (int i = 0; i < rdly; i++) begin
        @(negedge clk);
        chk(mem_req_valid == 1'b1 && mem_req_addr == ea, "R12 hold", mem_req_addr, ea);
      end
      mem_req_ready = 1;
      @(negedge clk);
      mem_req_ready = 0;
      chk(mem_req_valid == 1'b0, "R12 req drop", 64'(mem_req_valid), 64'd0);
      for (int i = 0; i < sdly; i++) begin
        @(negedge clk);
        chk(xl_rsp_valid == 1'b0 && xl_req_ready == 1'b0, "R12 waiting",
            {62'd0, xl_rsp_valid, xl_req_ready}, 64'd0);
      end
      mem_rsp_valid = 1; mem_rsp_data = swap8(ent);
      @(negedge clk);
      mem_rsp_valid = 0;
      exp_entry(ent, va, pa, rd, wr, bg);
      check_rsp("R8 R9 R10 R11 decode", pa, rd, wr, bg);
    end
    @(negedge clk);
    chk(xl_rsp_valid == 1'b0, "R12 single pulse", 64'(xl_rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, ctl, bas, va, ent;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(xl_req_ready && !xl_rsp_valid && !mem_req_valid, "R1 outputs",
        {61'd0, xl_req_ready, xl_rsp_valid, mem_req_valid}, 64'd4);
    reg_rd(5'h0, 1, d); chk(d == 0, "R1 ctrl zero", d, 0);
    reg_rd(5'h8, 1, d); chk(d == 0, "R1 base zero", d, 0);

    // R2 halves and widths
    reg_wr(5'h0, 1, 64'h1122_3344_5566_7788);
    reg_rd(5'h0, 0, d); chk(d == 64'h1122_3344, "R2 ctrl upper", d, 64'h1122_3344);
    reg_rd(5'h4, 0, d); chk(d == 64'h5566_7788, "R2 ctrl lower", d, 64'h5566_7788);
    reg_wr(5'h0, 0, 64'hFFFF_FFFF_DEAD_BEEF);
    reg_rd(5'h0, 1, d); chk(d == 64'hDEAD_BEEF_5566_7788, "R2 ctrl hi write", d, 64'hDEAD_BEEF_5566_7788);
    reg_wr(5'h8, 1, 64'hAAAA_BBBB_CCCC_DDDD);
    reg_wr(5'hC, 0, 64'h0000_0000_0BAD_F00D);
    reg_rd(5'h8, 1, d); chk(d == 64'hAAAA_BBBB_0BAD_F00D, "R2 base lo write", d, 64'hAAAA_BBBB_0BAD_F00D);
    reg_rd(5'h8, 0, d); chk(d == 64'hAAAA_BBBB, "R2 base upper", d, 64'hAAAA_BBBB);

    // R3 unmapped offsets
    reg_wr(5'h10, 1, '1); reg_wr(5'h14, 0, '1); reg_wr(5'h2, 0, '1); reg_wr(5'h4, 1, '1);
    reg_wr(5'h1C, 0, '1);
    reg_rd(5'h10, 1, d); chk(d == 0, "R3 read 0x10", d, 0);
    reg_rd(5'h14, 0, d); chk(d == 0, "R3 read 0x14", d, 0);
    reg_rd(5'h4, 1, d);  chk(d == 0, "R3 wide at 0x4", d, 0);
    reg_rd(5'h0, 1, d);  chk(d == 64'hDEAD_BEEF_5566_7788, "R3 ctrl kept", d, 64'hDEAD_BEEF_5566_7788);
    reg_rd(5'h8, 1, d);  chk(d == 64'hAAAA_BBBB_0BAD_F00D, "R3 base kept", d, 64'hAAAA_BBBB_0BAD_F00D);

    // R4 passthrough with format bits set but enable clear
    ctl = 64'h0000_0000_0007_0004;
    reg_wr(5'h0, 1, ctl);
    for (int i = 0; i < 6; i++) begin
      va = 64'h0123_4567_89AB_CDEF ^ (64'hF0F0_0000_0000_1357 << i);
      xlate(va, ctl, 64'hAAAA_BBBB_0BAD_F00D, 64'd0, 0, 0);
    end

    // R5 R6 R7 sweep over format and size codes
    for (int f = 0; f < 2; f++) begin
      for (int n = 0; n < 8; n++) begin
        for (int t = 0; t < 3; t++) begin
          ctl = 64'h00F0_0000_0000_0001 | (64'(f) << 2) | (64'(n) << 16);
          bas = 64'h0000_0012_3450_0000 + 64'(t) * 64'h0001_0008;
          reg_wr(5'h0, 1, ctl);
          reg_wr(5'h8, 0, bas >> 32);
          reg_wr(5'hC, 0, bas);
          case (t)
            0: va = 64'hFFFF_FFFF_FFFF_FFFF;
            1: va = 64'h0000_0000_5A5A_C3C3 ^ (64'(n) << 20);
            default: va = 64'h1234_5678_9ABC_DEF0;
          endcase
          ent = 64'h0000_01AB_CDEF_F00D ^ (64'(n) * 64'h1111_0000);
          ent[63] = !(n == 3 && t == 0);
          ent[61] = (t == 1) || (t == 2 && f == 1);
          ent[1]  = n[0];
          xlate(va, ctl, bas, ent, (n + t) % 3, t);
        end
      end
    end

    // R13 writes during a walk apply to the next request
    ctl = 64'h0000_0000_0000_0001;
    bas = 64'h0000_0000_8000_0000;
    reg_wr(5'h0, 1, ctl);
    reg_wr(5'h8, 1, bas);
    va  = 64'h0000_0000_0000_6123;
    ent = 64'hA000_0000_4444_0002;
    @(negedge clk);
    xl_req_valid = 1; xl_req_addr = va;
    @(negedge clk);
    xl_req_valid = 0;
    reg_en = 1; reg_we = 1; reg_wide = 1; reg_addr = 5'h0; reg_wdata = 64'd0;
    @(negedge clk);
    reg_addr = 5'h8; reg_wdata = 64'h0000_0000_0100_0000;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
    chk(mem_req_addr == 64'h0000_0000_8000_0018, "R13 addr kept", mem_req_addr, 64'h0000_0000_8000_0018);
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    mem_rsp_valid = 1; mem_rsp_data = swap8(ent);
    @(negedge clk);
    mem_rsp_valid = 0;
    check_rsp("R13 walk result", 64'h0000_0000_4444_6123, 1, 1, 1);
    xlate(64'h0000_7777_0000_1234, 64'd0, 64'h0100_0000, 64'd0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule